// File: doc/BRIEF.md
# Clock Source Selection Controller

This controller chooses which of three clock sources drives the system: the main oscillator, a multiplied PLL output or a slow sub clock. Software writes a 16-bit control register over a simple synchronous bus to request a source, to pick a stabilization wait length and to set the PLL multiplier code. The controller does not switch at once. It runs a down-counter whose length comes from the wait field, and for the PLL it also waits for the lock input. Only then does it move the select output and the read-only status bits to the new source.

A second register holds the top bit of the multiplier code. The block sends the select code and the multiplier code to an external glitch-free mux and PLL, which are outside this block. Everything runs in one reference-clock domain. The wait lengths are parameters given as powers of two: defaults 2^10, 2^13 and 2^17, and for wait code 11 either 2^16 (power-on reset) or 2^15 (any other reset).

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset, the control register reads 16'hFC00, the extension register reads 16'h0000, `clk_sel` is 2'b00 (main) and `mul_code` is 3'b000.
- R2: A control write (`bus_addr`=0) updates the wait field from bits 13:12, the sub request bit from bit 11, the PLL request bit from bit 10 and the low multiplier bits from bits 9:8. Write data in bits 15:14 and 7:0 has no effect, and bits 7:0 read as zero.
- R3: `mul_code` is {hi, bits 9:8 of the control register}. hi is written and read at bit 8 of the extension register (`bus_addr`=1), and the other bits of that register read as zero. `mul_code` changes only after a bus write.
- R4: A write that would make the multiplier code 3'b111 leaves the field it targets unchanged. The other fields in the same write are still updated.
- R5: The requested source is sub when bit 11 is 0, whatever bit 10 holds. Otherwise it is PLL when bit 10 is 0, and main when both are 1. `clk_sel` encodes main as 00, PLL as 01 and sub as 10, and it only ever moves to the source that was being requested.
- R6: After a write that requests a source different from the active one, `clk_sel` changes on the (N+1)th rising edge after the write edge. N is 2^E0, 2^E1 or 2^E2 for wait codes 00, 01 and 10.
- R7: For wait code 11, N is 2^E3P when `rst_por` is high and 2^E3O when it is low.
- R8: A switch to the PLL completes only on an edge where `pll_lock` is high. If the count has run out and lock is low, the switch waits, and it completes on the first edge with lock high.
- R9: A new request during a wait restarts the count for the new source. A request that returns to the active source cancels the pending switch.
- R10: Control register bit 15 reads 0 exactly while the sub clock is active, and bit 14 reads 0 exactly while the PLL is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects the control register, 1 the extension register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| rst_por | input | 1 | High when the last reset was a power-on reset |
| pll_lock | input | 1 | PLL lock indication |
| clk_sel | output | 2 | Active source code for the external mux |
| mul_code | output | 3 | Multiplier code for the PLL |

## Verification
A wrong target register or a wrong counter load shows up only when a switch completes. `clk_sel` and status bits 15:14 then change on the wrong edge or go to the wrong source, and the bench compares them with its model on every cycle. A stale multiplier or request field shows up on `bus_rdata` and `mul_code` on the first edge after the write. A pending switch that was not cancelled shows up after one full wait length, when the select moves although no source change is pending.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

   localparam int REG_W = 16;

   typedef enum logic [1:0] {
      SRC_MAIN = 2'b00,
      SRC_PLL  = 2'b01,
      SRC_SUB  = 2'b10
   } src_e;

   typedef struct packed {
      logic [1:0] ws;
      logic       scs;
      logic       mcs;
      logic [1:0] cs;
   } cfg_t;

   localparam cfg_t CFG_RST = '{ws: 2'b11, scs: 1'b1, mcs: 1'b1, cs: 2'b00};

   // Sub request outranks PLL request
   function automatic src_e decode_req(cfg_t c);
      if (!c.scs)      return SRC_SUB;
      else if (!c.mcs) return SRC_PLL;
      else             return SRC_MAIN;
   endfunction

endpackage

// File: rtl/clksrc_cfg.sv
module clksrc_cfg
   import clksrc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             addr,
   input  logic [REG_W-1:0] wdata,
   output cfg_t             cfg,
   output logic             mul_hi
);

   localparam int WS_LO  = 12;
   localparam int SCS_B  = 11;
   localparam int MCS_B  = 10;
   localparam int CS_LO  = 8;
   localparam int HI_B   = 8;

   logic unused_wbits;
   assign unused_wbits = ^{wdata[15:14], wdata[7:0]};

   logic cs_blocked;
   logic hi_blocked;

   // a write that would form code 111 keeps the targeted field
   assign cs_blocked = mul_hi && (wdata[CS_LO +: 2] == 2'b11);
   assign hi_blocked = wdata[HI_B] && (cfg.cs == 2'b11);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= CFG_RST;
         mul_hi <= 1'b0;
      end else if (we) begin
         if (!addr) begin
            cfg.ws  <= wdata[WS_LO +: 2];
            cfg.scs <= wdata[SCS_B];
            cfg.mcs <= wdata[MCS_B];
            if (!cs_blocked) cfg.cs <= wdata[CS_LO +: 2];
         end else if (!hi_blocked) begin
            mul_hi <= wdata[HI_B];
         end
      end
   end

endmodule

// File: rtl/clksrc_wait.sv
module clksrc_wait
   import clksrc_pkg::*;
#(
   parameter int E0        = 10,
   parameter int E1        = 13,
   parameter int E2        = 17,
   parameter int E3P       = 16,
   parameter int E3O       = 15,
   parameter bit LOCK_GATE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  src_e       req,
   input  logic [1:0] ws,
   input  logic       por,
   input  logic       pll_lock,
   output src_e       act
);

   localparam int EA   = (E0 > E1) ? E0 : E1;
   localparam int EB   = (E2 > E3P) ? E2 : E3P;
   localparam int EC   = (EA > EB) ? EA : EB;
   localparam int EMAX = (EC > E3O) ? EC : E3O;
   localparam int CW   = EMAX + 1;

   localparam logic [CW-1:0] LD0  = CW'((1 << E0) - 1);
   localparam logic [CW-1:0] LD1  = CW'((1 << E1) - 1);
   localparam logic [CW-1:0] LD2  = CW'((1 << E2) - 1);
   localparam logic [CW-1:0] LD3P = CW'((1 << E3P) - 1);
   localparam logic [CW-1:0] LD3O = CW'((1 << E3O) - 1);

   if (E0 < 1 || E1 < 1 || E2 < 1 || E3P < 1 || E3O < 1) begin : g_bad_lo
      $error("clksrc_wait: wait exponents must be at least 1");
   end
   if (EMAX > 30) begin : g_bad_hi
      $error("clksrc_wait: wait exponent above 30");
   end

   src_e          tgt;
   logic          busy;
   logic [CW-1:0] cnt;
   logic [CW-1:0] ld;
   logic          lock_ok;

   always_comb begin
      unique case (ws)
         2'b00:   ld = LD0;
         2'b01:   ld = LD1;
         2'b10:   ld = LD2;
         default: ld = por ? LD3P : LD3O;
      endcase
   end

   if (LOCK_GATE) begin : g_lock
      assign lock_ok = (tgt != SRC_PLL) || pll_lock;
   end else begin : g_nolock
      logic unused_lock;
      assign unused_lock = pll_lock;
      assign lock_ok     = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt  <= SRC_MAIN;
         act  <= SRC_MAIN;
         busy <= 1'b0;
         cnt  <= '0;
      end else if (req != tgt) begin
         tgt  <= req;
         cnt  <= ld;
         busy <= (req != act);
      end else if (busy) begin
         if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else if (lock_ok) begin
            act  <= tgt;
            busy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
   import clksrc_pkg::*;
#(
   parameter int E0        = 10,
   parameter int E1        = 13,
   parameter int E2        = 17,
   parameter int E3P       = 16,
   parameter int E3O       = 15,
   parameter bit LOCK_GATE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_we,
   input  logic        bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        rst_por,
   input  logic        pll_lock,
   output logic [1:0]  clk_sel,
   output logic [2:0]  mul_code
);

   cfg_t       cfg;
   logic       mul_hi;
   src_e       req_e;
   src_e       act_e;
   logic [1:0] req_src;

   clksrc_cfg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .cfg    (cfg),
      .mul_hi (mul_hi)
   );

   assign req_e   = decode_req(cfg);
   assign req_src = req_e;

   clksrc_wait #(
      .E0        (E0),
      .E1        (E1),
      .E2        (E2),
      .E3P       (E3P),
      .E3O       (E3O),
      .LOCK_GATE (LOCK_GATE)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_e),
      .ws       (cfg.ws),
      .por      (rst_por),
      .pll_lock (pll_lock),
      .act      (act_e)
   );

   assign clk_sel  = act_e;
   assign mul_code = {mul_hi, cfg.cs};

   always_comb begin
      if (!bus_addr)
         bus_rdata = {act_e != SRC_SUB, act_e != SRC_PLL, cfg, 8'h00};
      else
         bus_rdata = {7'b0, mul_hi, 8'h00};
   end

endmodule

// File: rtl/clksrc_chk.sv
module clksrc_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_we,
   input logic        bus_addr,
   input logic [15:0] bus_rdata,
   input logic        pll_lock,
   input logic [1:0]  clk_sel,
   input logic [2:0]  mul_code,
   input logic [1:0]  req_src
);

   a_r4_no_forbidden: assert property (@(posedge clk) disable iff (!rst_n)
      mul_code != 3'b111);

   a_r3_mul_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we) |-> $stable(mul_code));

   a_r8_pll_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 2'b01 && $past(clk_sel) != 2'b01) |-> $past(pll_lock));

   a_r5_to_request: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel != $past(clk_sel)) |-> (clk_sel == $past(req_src)));

   a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel != 2'b11);

   a_r10_sub_status: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_addr |-> (bus_rdata[15] == (clk_sel != 2'b10)));

   a_r10_pll_status: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_addr |-> (bus_rdata[14] == (clk_sel != 2'b01)));

endmodule

bind clksrc_ctrl clksrc_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pll_lock  (pll_lock),
   .clk_sel   (clk_sel),
   .mul_code  (mul_code),
   .req_src   (req_src)
);

// File: tb/sim_clksrc_ctrl.sv
`timescale 1ns/1ps
module sim_clksrc_ctrl;

   localparam int E0 = 3, E1 = 4, E2 = 6, E3P = 5, E3O = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_addr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rst_por = 1'b1;
   logic        pll_lock = 1'b0;
   logic [1:0]  clk_sel;
   logic [2:0]  mul_code;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   clksrc_ctrl #(.E0(E0), .E1(E1), .E2(E2), .E3P(E3P), .E3O(E3O)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_por(rst_por),
      .pll_lock(pll_lock), .clk_sel(clk_sel), .mul_code(mul_code)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model: 0 main, 1 pll, 2 sub
   int m_ws, m_scs, m_mcs, m_cs, m_hi, m_act, m_tgt, m_rem;

   function automatic int nwait(int ws);
      case (ws)
         0: return 1 << E0;
         1: return 1 << E1;
         2: return 1 << E2;
         default: return rst_por ? (1 << E3P) : (1 << E3O);
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ws = 3; m_scs = 1; m_mcs = 1; m_cs = 0; m_hi = 0;
         m_act = 0; m_tgt = 0; m_rem = -1;
      end else begin
         int rq;
         rq = (m_scs == 0) ? 2 : ((m_mcs == 0) ? 1 : 0);
         if (rq != m_tgt) begin
            m_tgt = rq;
            m_rem = (rq == m_act) ? -1 : nwait(m_ws) - 1;
         end else if (m_rem > 0) begin
            m_rem--;
         end else if (m_rem == 0 && (m_tgt != 1 || pll_lock)) begin
            m_act = m_tgt;
            m_rem = -1;
         end
         if (bus_we) begin
            if (!bus_addr) begin
               m_ws  = int'(bus_wdata[13:12]);
               m_scs = int'(bus_wdata[11]);
               m_mcs = int'(bus_wdata[10]);
               if (!(m_hi == 1 && bus_wdata[9:8] == 2'b11)) m_cs = int'(bus_wdata[9:8]);
            end else if (!(bus_wdata[8] && m_cs == 3)) begin
               m_hi = int'(bus_wdata[8]);
            end
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [15:0] er;
         if (!bus_addr)
            er = {m_act != 2, m_act != 1, 2'(m_ws), 1'(m_scs), 1'(m_mcs), 2'(m_cs), 8'h00};
         else
            er = {7'b0, 1'(m_hi), 8'h00};
         chk("R6 model clk_sel", 32'(clk_sel), 32'(m_act));
         chk("R3 model mul_code", 32'(mul_code), 32'({m_hi[0], 2'(m_cs)}));
         chk("R2 model rdata", 32'(bus_rdata), 32'(er));
      end
   end

   function automatic logic [15:0] word(input logic [1:0] ws, input logic scs,
                                       input logic mcs, input logic [1:0] cs);
      return {2'b00, ws, scs, mcs, cs, 8'h5A};
   endfunction

   task automatic wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 1'b0;
   endtask

   task automatic meas(input logic [15:0] d, output int k);
      logic [1:0] old;
      old = clk_sel;
      wr(1'b0, d);
      k = 0;
      while (clk_sel == old && k < 5000) begin
         @(posedge clk); #1; k++;
      end
   endtask

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 ctrl reset", 32'(bus_rdata), 32'hFC00);
      chk("R1 clk_sel reset", 32'(clk_sel), 0);
      chk("R1 mul reset", 32'(mul_code), 0);
      bus_addr = 1'b1; #1;
      chk("R1 ext reset", 32'(bus_rdata), 0);
      bus_addr = 1'b0;

      wr(1'b0, word(2'b01, 1'b1, 1'b1, 2'b10)); #1;
      chk("R2 readback, status and low byte ignored", 32'(bus_rdata), 32'hDE00);

      wr(1'b1, 16'hFFFF); #1;
      chk("R3 mul code with hi", 32'(mul_code), 3'b110);
      bus_addr = 1'b1; #1;
      chk("R3 ext readback", 32'(bus_rdata), 32'h0100);
      bus_addr = 1'b0;

      wr(1'b0, word(2'b00, 1'b1, 1'b1, 2'b11)); #1;
      chk("R4 low bits kept", 32'(mul_code), 3'b110);
      chk("R4 other fields written", 32'(bus_rdata[13:12]), 0);
      wr(1'b1, 16'h0000);
      wr(1'b0, word(2'b00, 1'b1, 1'b1, 2'b11));
      wr(1'b1, 16'h0100); #1;
      chk("R4 hi kept", 32'(mul_code), 3'b011);

      meas(word(2'b00, 1'b0, 1'b1, 2'b00), k);
      chk("R6 wait code 00 latency", k, (1 << E0) + 1);
      chk("R10 sub status", 32'(bus_rdata[15:14]), 2'b01);
      meas(word(2'b01, 1'b1, 1'b1, 2'b00), k);
      chk("R6 wait code 01 latency", k, (1 << E1) + 1);
      meas(word(2'b10, 1'b0, 1'b0, 2'b00), k);
      chk("R6 wait code 10 latency", k, (1 << E2) + 1);
      chk("R5 sub outranks pll", 32'(clk_sel), 2'b10);
      meas(word(2'b00, 1'b1, 1'b1, 2'b00), k);

      rst_por = 1'b1;
      meas(word(2'b11, 1'b0, 1'b1, 2'b00), k);
      chk("R7 code 11 after power-on", k, (1 << E3P) + 1);
      meas(word(2'b00, 1'b1, 1'b1, 2'b00), k);
      rst_por = 1'b0;
      meas(word(2'b11, 1'b0, 1'b1, 2'b00), k);
      chk("R7 code 11 other reset", k, (1 << E3O) + 1);
      meas(word(2'b00, 1'b1, 1'b1, 2'b00), k);

      pll_lock = 1'b0;
      wr(1'b0, word(2'b00, 1'b1, 1'b0, 2'b00));
      repeat (20) @(posedge clk);
      #1;
      chk("R8 held without lock", 32'(clk_sel), 2'b00);
      @(negedge clk); pll_lock = 1'b1;
      @(posedge clk); #1;
      chk("R8 switch on lock", 32'(clk_sel), 2'b01);
      chk("R10 pll status", 32'(bus_rdata[15:14]), 2'b10);
      meas(word(2'b00, 1'b1, 1'b1, 2'b00), k);
      chk("R5 back to main", 32'(clk_sel), 2'b00);

      wr(1'b0, word(2'b01, 1'b0, 1'b1, 2'b00));
      repeat (5) @(posedge clk);
      wr(1'b0, word(2'b01, 1'b1, 1'b1, 2'b00));
      repeat (40) @(posedge clk);
      #1;
      chk("R9 cancel on return to active", 32'(clk_sel), 2'b00);

      wr(1'b0, word(2'b01, 1'b0, 1'b1, 2'b00));
      repeat (5) @(posedge clk);
      meas(word(2'b00, 1'b1, 1'b0, 2'b00), k);
      chk("R9 restart latency", k, (1 << E0) + 1);
      chk("R9 new target taken", 32'(clk_sel), 2'b01);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      done = 1;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule